// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block holds the 64-bit HI and LO result registers of an integer core. It runs multiply and divide commands iteratively, one operand bit per clock. Commands may be signed or unsigned, on 32-bit or 64-bit operands. When a command finishes, the block writes both registers. Move-to commands load either register directly from the first operand. Both registers are always visible on the outputs, so a move-from needs nothing beyond the current value.

Each issued instruction is presented for one cycle with `issue_i` high. Its six-bit function code is on `funct_i`. Every issued code takes one instruction slot, including codes that do not touch HI or LO. A read of HI or LO is corrupted if either of the next two issued instructions writes the register that was read. The block flags that case combinationally in the issuing cycle, so that a neighbouring pipeline can stall or reorder.

Top module: `muldiv_unit`

## Requirements
- R1: Function code 011000 (signed) or 011001 (unsigned) multiplies the low 32 bits of both operands. LO takes the low word of the product and HI takes the high word, each sign-extended from its bit 31.
- R2: Function code 011100 (signed) or 011101 (unsigned) multiplies full 64-bit operands. LO takes the low 64 bits of the 128-bit product and HI takes the high 64 bits.
- R3: Function code 011010 (signed) or 011011 (unsigned) divides the low 32 bits of the first operand by the low 32 bits of the second. The quotient goes to LO and the remainder to HI, each sign-extended from bit 31.
- R4: Function code 011110 (signed) or 011111 (unsigned) divides 64-bit operands, with the 64-bit quotient in LO and the 64-bit remainder in HI.
- R5: A signed divide truncates the quotient toward zero, and the remainder carries the sign of the dividend.
- R6: When idle, code 010001 loads all 64 bits of `rs_i` into HI at the next clock edge, and code 010011 does the same for LO. Codes 010000 and 010010 are reads; they change nothing and are served from `hi_o` and `lo_o`.
- R7: An arithmetic command accepted at clock edge E raises `busy_o` from E on. HI, LO and a one-cycle `done_o` pulse all update at edge E+W+1, where W is 32 or 64 according to the operand size. `busy_o` is low while `done_o` is high.
- R8: An arithmetic or move-to command issued while `busy_o` is high has no effect on HI, LO or the running operation.
- R9: `hazard_o` is high in a cycle where `issue_i` presents an HI-writing code (010001 or any arithmetic code) and one of the two previously issued slots was 010000. The same holds for LO-writing codes (010011 or arithmetic) after 010010. The flag is independent of `busy_o`.
- R10: An unsigned divide by zero completes normally. LO is all ones, sign-extended from bit 31 for the 32-bit form, and HI is the dividend as R3 or R4 would place it.
- R11: After reset, HI and LO are zero and `busy_o`, `done_o` and `hazard_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | An instruction occupies this cycle's slot |
| funct_i | input | 6 | Function code of the issued instruction |
| rs_i | input | 64 | First operand (dividend, multiplicand, move-to source) |
| rt_i | input | 64 | Second operand (divisor, multiplier) |
| busy_o | output | 1 | An arithmetic operation is in progress |
| done_o | output | 1 | One-cycle pulse when HI and LO receive a result |
| hazard_o | output | 1 | Issued write collides with a recent read of the same register |
| hi_o | output | 64 | Current HI register |
| lo_o | output | 64 | Current LO register |

## Verification
Two events can land in the same cycle: a move-to or hazard-flagged write is issued, and a running divide writes its result. The bench starts a 32-bit divide and counts cycles until the last busy cycle. In that cycle it issues a read of LO followed by a move-to-LO. It then checks three things: the hazard flag rises, the final LO equals the quotient rather than the moved value, and the done pulse arrives exactly W+1 edges after acceptance.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam logic [5:0] F_MFHI = 6'b010000;
  localparam logic [5:0] F_MTHI = 6'b010001;
  localparam logic [5:0] F_MFLO = 6'b010010;
  localparam logic [5:0] F_MTLO = 6'b010011;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} md_state_e;

  // arithmetic group 011xyz: x = 64-bit, y = divide, z = unsigned
  function automatic logic is_arith(input logic [5:0] f);
    return f[5:3] == 3'b011;
  endfunction
endpackage

// File: rtl/muldiv_hazard.sv
module muldiv_hazard #(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic rd_hi_i,
  input  logic rd_lo_i,
  input  logic wr_hi_i,
  input  logic wr_lo_i,
  output logic hazard_o
);
  logic [DEPTH-1:0] hist_hi, hist_lo;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic nxt_hi, nxt_lo;
    if (i == 0) begin : g_head
      assign nxt_hi = rd_hi_i;
      assign nxt_lo = rd_lo_i;
    end else begin : g_tail
      assign nxt_hi = hist_hi[i-1];
      assign nxt_lo = hist_lo[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hist_hi[i] <= 1'b0;
        hist_lo[i] <= 1'b0;
      end else if (issue_i) begin
        hist_hi[i] <= nxt_hi;
        hist_lo[i] <= nxt_lo;
      end
    end
  end

  assign hazard_o = issue_i & ((wr_hi_i & |hist_hi) | (wr_lo_i & |hist_lo));

  // R9: a read slot is remembered for the next issue
  a_r9_read_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && rd_hi_i) |=> hist_hi[0]);
  a_r9_flag_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hazard_o |-> (issue_i && (wr_hi_i || wr_lo_i)));
endmodule

// File: rtl/muldiv_core.sv
module muldiv_core import muldiv_pkg::*; #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            dword_i,
  input  logic            div_i,
  input  logic            uns_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            busy_o,
  output logic            wr_o,
  output logic [XLEN-1:0] res_hi_o,
  output logic [XLEN-1:0] res_lo_o
);
  localparam int HALF = XLEN / 2;
  localparam int PW   = 2 * XLEN;
  localparam int CW   = $clog2(XLEN + 1);

  md_state_e       state_q;
  logic [PW-1:0]   acc_q;
  logic [XLEN-1:0] opa_q, sh_q, rem_q;
  logic [CW-1:0]   cnt_q;
  logic            neg_q, neg_r, div_q, dw_q;

  // operand conditioning: width select, extension, magnitude
  logic [XLEN-1:0] op_in  [2];
  logic [XLEN-1:0] op_mag [2];
  logic            op_neg [2];
  assign op_in[0] = a_i;
  assign op_in[1] = b_i;

  for (genvar k = 0; k < 2; k++) begin : g_opnd
    logic [XLEN-1:0] ext;
    always_comb begin
      if (dword_i)    ext = op_in[k];
      else if (uns_i) ext = {{HALF{1'b0}}, op_in[k][HALF-1:0]};
      else            ext = {{HALF{op_in[k][HALF-1]}}, op_in[k][HALF-1:0]};
      op_neg[k] = !uns_i && ext[XLEN-1];
      op_mag[k] = op_neg[k] ? -ext : ext;
    end
  end

  // one iteration step
  logic [XLEN:0]   rem_sh;
  logic            ge;
  logic [XLEN:0]   rem_sub;
  always_comb begin
    rem_sh  = {rem_q, sh_q[XLEN-1]};
    ge      = rem_sh >= {1'b0, opa_q};
    rem_sub = rem_sh - {1'b0, opa_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      acc_q   <= '0;
      opa_q   <= '0;
      sh_q    <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
      neg_q   <= 1'b0;
      neg_r   <= 1'b0;
      div_q   <= 1'b0;
      dw_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_RUN;
          div_q   <= div_i;
          dw_q    <= dword_i;
          acc_q   <= '0;
          rem_q   <= '0;
          cnt_q   <= dword_i ? CW'(XLEN) : CW'(HALF);
          neg_q   <= op_neg[0] ^ op_neg[1];
          neg_r   <= op_neg[0];
          if (div_i) begin
            opa_q <= op_mag[1];
            sh_q  <= dword_i ? op_mag[0] : (op_mag[0] << HALF);
          end else begin
            opa_q <= op_mag[0];
            sh_q  <= dword_i ? op_mag[1] : (op_mag[1] << HALF);
          end
        end
        S_RUN: begin
          if (div_q) begin
            rem_q <= ge ? rem_sub[XLEN-1:0] : rem_sh[XLEN-1:0];
            sh_q  <= {sh_q[XLEN-2:0], ge};
          end else begin
            acc_q <= {acc_q[PW-2:0], 1'b0} + (sh_q[XLEN-1] ? {{XLEN{1'b0}}, opa_q} : '0);
            sh_q  <= {sh_q[XLEN-2:0], 1'b0};
          end
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) state_q <= S_FIN;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // sign fix and placement
  logic [PW-1:0]   prod;
  logic [XLEN-1:0] quo, rmd, full_hi, full_lo;
  logic [HALF-1:0] half_hi, half_lo;
  always_comb begin
    prod = neg_q ? -acc_q : acc_q;
    quo  = neg_q ? -sh_q : sh_q;
    rmd  = neg_r ? -rem_q : rem_q;
    if (div_q) begin
      full_hi = rmd;
      full_lo = quo;
      half_hi = rmd[HALF-1:0];
      half_lo = quo[HALF-1:0];
    end else begin
      full_hi = prod[PW-1:XLEN];
      full_lo = prod[XLEN-1:0];
      half_hi = prod[XLEN-1:HALF];
      half_lo = prod[HALF-1:0];
    end
    res_hi_o = dw_q ? full_hi : {{HALF{half_hi[HALF-1]}}, half_hi};
    res_lo_o = dw_q ? full_lo : {{HALF{half_lo[HALF-1]}}, half_lo};
  end

  assign busy_o = state_q != S_IDLE;
  assign wr_o   = state_q == S_FIN;

  // R7: iteration count never underflows and finish follows a run
  a_r7_cnt_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RUN) |-> (cnt_q != '0));
  a_r7_fin_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FIN) |-> ($past(state_q) == S_RUN));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit import muldiv_pkg::*; #(
  parameter int XLEN      = 64,
  parameter int HAZ_DEPTH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_i,
  input  logic [5:0]      funct_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            hazard_o,
  output logic [XLEN-1:0] hi_o,
  output logic [XLEN-1:0] lo_o
);
  logic arith, mthi, mtlo, start, core_wr;
  logic [XLEN-1:0] res_hi, res_lo;

  assign arith = is_arith(funct_i);
  assign mthi  = funct_i == F_MTHI;
  assign mtlo  = funct_i == F_MTLO;
  assign start = issue_i && !busy_o && arith;

  muldiv_core #(.XLEN(XLEN)) core_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .dword_i  (funct_i[2]),
    .div_i    (funct_i[1]),
    .uns_i    (funct_i[0]),
    .a_i      (rs_i),
    .b_i      (rt_i),
    .busy_o   (busy_o),
    .wr_o     (core_wr),
    .res_hi_o (res_hi),
    .res_lo_o (res_lo)
  );

  muldiv_hazard #(.DEPTH(HAZ_DEPTH)) haz_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .issue_i  (issue_i),
    .rd_hi_i  (funct_i == F_MFHI),
    .rd_lo_i  (funct_i == F_MFLO),
    .wr_hi_i  (arith || mthi),
    .wr_lo_i  (arith || mtlo),
    .hazard_o (hazard_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o   <= '0;
      lo_o   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= core_wr;
      if (core_wr) begin
        hi_o <= res_hi;
        lo_o <= res_lo;
      end else if (issue_i && !busy_o) begin
        if (mthi) hi_o <= rs_i;
        if (mtlo) lo_o <= rs_i;
      end
    end
  end

  a_r6_mthi_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !busy_o && mthi) |=> (hi_o == $past(rs_i)));
  a_r7_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !core_wr) |=> ($stable(hi_o) && $stable(lo_o)));
endmodule

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] MFHI = 6'b010000, MTHI = 6'b010001;
  localparam logic [5:0] MFLO = 6'b010010, MTLO = 6'b010011;
  localparam logic [5:0] MULT = 6'b011000, MULTU = 6'b011001;
  localparam logic [5:0] DIV = 6'b011010, DIVU = 6'b011011;
  localparam logic [5:0] DMULT = 6'b011100, DMULTU = 6'b011101;
  localparam logic [5:0] DDIV = 6'b011110, DDIVU = 6'b011111;
  localparam logic [5:0] OTHER = 6'b100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue = 1'b0;
  logic [5:0] funct = '0;
  logic [63:0] rs = '0, rt = '0;
  logic busy, done, hazard;
  logic [63:0] hi, lo;

  muldiv_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .funct_i(funct),
    .rs_i(rs), .rt_i(rt), .busy_o(busy), .done_o(done),
    .hazard_o(hazard), .hi_o(hi), .lo_o(lo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int n_chk = 0, n_bad = 0;

  typedef struct {
    logic [63:0] hi;
    logic [63:0] lo;
    int          due;
    string       req;
  } exp_t;
  exp_t sb[$];

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic void model(input logic [5:0] f, input logic [63:0] a, b,
                                output logic [63:0] eh, output logic [63:0] el);
    logic dw, dv, un;
    logic [63:0] ae, be, q, r;
    logic signed [127:0] pa, pb, p;
    dw = f[2]; dv = f[1]; un = f[0];
    if (dw) begin ae = a; be = b; end
    else if (un) begin ae = {32'b0, a[31:0]}; be = {32'b0, b[31:0]}; end
    else begin ae = sx(a[31:0]); be = sx(b[31:0]); end
    if (!dv) begin
      pa = un ? {64'b0, ae} : {{64{ae[63]}}, ae};
      pb = un ? {64'b0, be} : {{64{be[63]}}, be};
      p = pa * pb;
      eh = dw ? p[127:64] : sx(p[63:32]);
      el = dw ? p[63:0]   : sx(p[31:0]);
    end else begin
      if (be == 0) begin
        q = '1; r = ae;
      end else if (un) begin
        q = ae / be; r = ae % be;
      end else begin
        q = $signed(ae) / $signed(be); r = $signed(ae) % $signed(be);
      end
      eh = dw ? r : sx(r[31:0]);
      el = dw ? q : sx(q[31:0]);
    end
  endfunction

  // driver: one issued slot per call, entered and left at a negedge
  task automatic issue_op(input logic [5:0] f, input logic [63:0] a, b,
                          input bit push, input string req);
    exp_t e;
    if (push) begin
      model(f, a, b, e.hi, e.lo);
      e.due = cyc + (f[2] ? 64 : 32) + 2;
      e.req = req;
      sb.push_back(e);
    end
    issue = 1'b1; funct = f; rs = a; rt = b;
    @(negedge clk);
    issue = 1'b0; funct = OTHER;
  endtask

  task automatic issue_haz(input logic [5:0] f, input logic [63:0] a,
                           input bit exp_h, input bit push, input string req);
    issue = 1'b1; funct = f; rs = a; rt = 64'd3;
    #1 check(req, "hazard", {63'b0, hazard}, {63'b0, exp_h});
    issue = 1'b0;
    issue_op(f, a, 64'd3, push, req);
  endtask

  task automatic run(input logic [5:0] f, input logic [63:0] a, b, input string req);
    issue_op(f, a, b, 1'b1, req);
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compare results and latency as they complete
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R7 unexpected done: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, "HI", hi, e.hi);
        check(e.req, "LO", lo, e.lo);
        check("R7", "latency", 64'(cyc), 64'(e.due));
        check("R7", "busy at done", {63'b0, busy}, 64'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "HI", hi, 64'd0);
    check("R11", "LO", lo, 64'd0);
    check("R11", "busy/done/hazard", {61'b0, busy, done, hazard}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: 32-bit multiply, upper operand bits must not matter
    run(MULT,  64'hDEAD_0000_FFFF_FFFD, 64'h1234_5678_0000_0007, "R1");
    run(MULT,  64'h7FFF_FFFF, 64'h7FFF_FFFF, "R1");
    run(MULTU, 64'hFFFF_FFFF, 64'hFFFF_FFFF, "R1");
    // R2: 64-bit multiply
    run(DMULT,  -64'sd5, 64'h1_2345_6789, "R2");
    run(DMULTU, '1, '1, "R2");
    run(DMULT,  64'h8000_0000_0000_0000, 64'd3, "R2");
    // R3 / R5: 32-bit divide
    run(DIV,  64'd100, 64'd7, "R3");
    run(DIVU, 64'hFFFF_FFF0, 64'd3, "R3");
    run(DIV,  -64'sd7, 64'd2, "R5");
    run(DIV,  64'd7, -64'sd2, "R5");
    // R4 / R5: 64-bit divide
    run(DDIVU, 64'hFEDC_BA98_7654_3210, 64'h1_0000_0001, "R4");
    run(DDIV,  -64'sd1000000000000, 64'd37, "R5");
    // R10: divide by zero
    run(DIVU,  64'h8000_1234, 64'd0, "R10");
    run(DDIVU, 64'h0123_4567_89AB_CDEF, 64'd0, "R10");

    // R6: moves
    issue_op(MTHI, 64'hA5A5_0000_1111_2222, '0, 1'b0, "R6");
    check("R6", "HI after move", hi, 64'hA5A5_0000_1111_2222);
    issue_op(MTLO, 64'h0F0F_F0F0_3333_4444, '0, 1'b0, "R6");
    check("R6", "LO after move", lo, 64'h0F0F_F0F0_3333_4444);
    issue_op(MFHI, '0, '0, 1'b0, "R6");
    check("R6", "HI after read", hi, 64'hA5A5_0000_1111_2222);

    // R7 / R8 / R9: moves during a divide, last one in its final busy cycle
    @(negedge clk);
    check("R7", "idle before start", {63'b0, busy}, 64'd0);
    issue_op(DIVU, 64'd100, 64'd7, 1'b1, "R8");
    check("R7", "busy after accept", {63'b0, busy}, 64'd1);
    issue_op(MTHI, 64'hBAD0, '0, 1'b0, "R8");
    repeat (30) @(negedge clk);
    check("R7", "busy in last cycle", {63'b0, busy}, 64'd1);
    issue_haz(MFLO, '0, 1'b0, 1'b0, "R9");
    issue_haz(MTLO, 64'hBAD1, 1'b1, 1'b0, "R9");
    check("R8", "LO after busy move", lo, 64'd14);
    check("R8", "HI after busy move", hi, 64'd2);

    // R9: hazard window
    issue_haz(MFHI,  '0, 1'b0, 1'b0, "R9");
    issue_haz(MTHI,  64'd1, 1'b1, 1'b0, "R9");
    issue_haz(OTHER, '0, 1'b0, 1'b0, "R9");
    issue_haz(MTHI,  64'd2, 1'b0, 1'b0, "R9");
    issue_haz(MFLO,  '0, 1'b0, 1'b0, "R9");
    issue_haz(OTHER, '0, 1'b0, 1'b0, "R9");
    issue_haz(MTLO,  64'd3, 1'b1, 1'b0, "R9");
    issue_haz(MFLO,  '0, 1'b0, 1'b0, "R9");
    issue_haz(OTHER, '0, 1'b0, 1'b0, "R9");
    issue_haz(OTHER, '0, 1'b0, 1'b0, "R9");
    issue_haz(MTLO,  64'd4, 1'b0, 1'b0, "R9");
    issue_haz(MFLO,  '0, 1'b0, 1'b0, "R9");
    issue_haz(MTHI,  64'd5, 1'b0, 1'b0, "R9");
    issue_haz(MFHI,  '0, 1'b0, 1'b0, "R9");
    issue_haz(MULT,  64'd6, 1'b1, 1'b1, "R9");
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule